// File: doc/BRIEF.md
# SMBus Host Notify Receiver

This block sits on the host side of an SMBus segment. It takes the host's own target address and lets devices that have become bus masters report events to it. A separate I2C target bit engine handles line timing. It hands the block a stream of events: start (including repeated start), stop, and received bytes. For each received byte the block answers with an acknowledge decision.

The block recognises the Host Notify frame. This frame has the shape of a word write: the host address with the write direction, one byte that carries the sender's own address, then a low data byte and a high data byte, then stop. The block records the reporting device's 7-bit address and the 16-bit data word. A notification is queued only when a complete and well-formed frame has ended with stop. Queued notifications wait in a small FIFO and hold an interrupt line high. Software reads the oldest entry from the output ports and removes it with a one-cycle pop strobe.

Top module: `hostnotify_rx`

## Requirements
- R1: After reset, irq and ackOut are low and the queue is empty.
- R2: A byte received as the first byte after a start is acknowledged when it equals 0x10, which is 7-bit address 0x08 with bit 0 = 0 for write. ackOut takes the decision in the cycle after the evByte pulse and holds it until the next evByte.
- R3: Any other first byte is NACKed, including 0x11 (read direction) and other addresses. Every later byte of that frame is also NACKed, and nothing is queued.
- R4: The first byte after a matching address byte supplies the device address, taken from its bits 7:1. Bit 0 is dropped.
- R5: The next two bytes are the low and the high data byte. notifyData presents them as {high, low}. The device-address byte and both data bytes are acknowledged.
- R6: An entry is queued only when stop follows exactly three bytes after the address byte. A stop after fewer bytes discards the partial frame.
- R7: A repeated start discards any partial frame. The byte after it is treated as a new address byte.
- R8: A fourth byte after the address byte is NACKed, and the frame is then discarded at stop.
- R9: The queue holds 4 entries in arrival order. notifyDev and notifyData show the oldest entry. irq is high exactly while the queue is not empty.
- R10: When the queue is full, the device-address byte is NACKed, the frame is dropped, and the queued entries stay unchanged.
- R11: A pop strobe while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evStart | input | 1 | Start or repeated start seen (one-cycle pulse) |
| evStop | input | 1 | Stop seen (one-cycle pulse) |
| evByte | input | 1 | A received byte is on byteData (one-cycle pulse) |
| byteData | input | 8 | Received byte |
| ackOut | output | 1 | Acknowledge decision for the last received byte |
| popStrobe | input | 1 | Remove the oldest queued notification |
| irq | output | 1 | High while any notification is queued |
| notifyDev | output | 7 | Device address of the oldest entry |
| notifyData | output | 16 | Data word of the oldest entry |

## Verification
The hardest case to reach from the ports is a full queue meeting a fresh notification. The bench commits four frames without popping, then sends a fifth. It checks that the fifth frame's address byte is still acknowledged while its device byte is refused. It then drains the queue and confirms that only the four original entries come out, in order. Because the write pointer wraps during this sequence, the bench also checks a frame sent after a pop on an empty queue. That frame must appear intact at the head.

// File: rtl/hn_pkg.sv
package hn_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_DEV, S_LOW, S_HIGH, S_DONE, S_SKIP
  } hnState_t;

  typedef struct packed {
    logic capDev;
    logic capLow;
    logic capHigh;
    logic push;
  } hnStrobe_t;
endpackage

// File: rtl/hn_ctrl.sv
module hn_ctrl
  import hn_pkg::*;
#(
  parameter logic [6:0] HOST_ADDR = 7'h08
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      evStart,
  input  logic      evStop,
  input  logic      evByte,
  input  logic [7:0] byteData,
  input  logic      fifoFull,
  output hnStrobe_t strb,
  output logic      ackOut
);
  localparam logic [7:0] MATCH_BYTE = {HOST_ADDR, 1'b0};

  hnState_t state, stateNext;
  logic     ackNext;

  always_comb begin
    stateNext = state;
    ackNext   = ackOut;
    strb      = '0;
    if (evStart) begin
      stateNext = S_ADDR;
    end else if (evStop) begin
      strb.push = (state == S_DONE);
      stateNext = S_IDLE;
    end else if (evByte) begin
      ackNext = 1'b0;
      case (state)
        S_ADDR: begin
          if (byteData == MATCH_BYTE) begin
            ackNext   = 1'b1;
            stateNext = S_DEV;
          end else begin
            stateNext = S_SKIP;
          end
        end
        S_DEV: begin
          if (fifoFull) begin
            stateNext = S_SKIP;
          end else begin
            ackNext     = 1'b1;
            strb.capDev = 1'b1;
            stateNext   = S_LOW;
          end
        end
        S_LOW: begin
          ackNext     = 1'b1;
          strb.capLow = 1'b1;
          stateNext   = S_HIGH;
        end
        S_HIGH: begin
          ackNext      = 1'b1;
          strb.capHigh = 1'b1;
          stateNext    = S_DONE;
        end
        S_DONE:  stateNext = S_SKIP;
        default: stateNext = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      ackOut <= 1'b0;
    end else begin
      state  <= stateNext;
      ackOut <= ackNext;
    end
  end

  // R6: a commit only ever coincides with a stop event
  p_push_on_stop_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> evStop);

  // R3: a foreign or read-direction address byte is refused
  p_foreign_nack_r3: assert property (@(posedge clk) disable iff (!rstN)
    (evByte && !evStart && !evStop && state == S_ADDR && byteData != MATCH_BYTE) |=> !ackOut);

  // R10: the device byte is refused while the queue is full
  p_full_nack_r10: assert property (@(posedge clk) disable iff (!rstN)
    (evByte && !evStart && !evStop && state == S_DEV && fifoFull) |=> !ackOut);

  // R8: a byte beyond the third data-phase byte is refused
  p_extra_nack_r8: assert property (@(posedge clk) disable iff (!rstN)
    (evByte && !evStart && !evStop && state == S_DONE) |=> (!ackOut && state == S_SKIP));
endmodule

// File: rtl/hn_data.sv
module hn_data
  import hn_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  hnStrobe_t   strb,
  input  logic [7:0]  byteData,
  input  logic [6:0]  devIn,
  input  logic        popReq,
  output logic        full,
  output logic        empty,
  output logic [6:0]  headDev,
  output logic [15:0] headData
);
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int ENTRY_W = 7 + 16;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [6:0]         devReg;
  logic [7:0]         lowReg, highReg;
  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic [CNT_W-1:0]   count;
  logic               doPush, doPop;

  assign full   = (count == FULL_CNT);
  assign empty  = (count == '0);
  assign doPush = strb.push && !full;
  assign doPop  = popReq && !empty;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      devReg  <= '0;
      lowReg  <= '0;
      highReg <= '0;
    end else begin
      if (strb.capDev)  devReg  <= devIn;
      if (strb.capLow)  lowReg  <= byteData;
      if (strb.capHigh) highReg <= byteData;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= {devReg, highReg, lowReg};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign {headDev, headData} = mem[rdPtr];

  // R10: the control never commits into a full queue
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> !full);

  // R11: popping an empty queue leaves it untouched
  p_pop_empty_r11: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && empty && !strb.push) |=> ($stable(rdPtr) && count == '0));

  // R9: occupancy stays within the queue depth
  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);
endmodule

// File: rtl/hostnotify_rx.sv
module hostnotify_rx
  import hn_pkg::*;
#(
  parameter logic [6:0] HOST_ADDR = 7'h08,
  parameter int         DEPTH     = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        evStart,
  input  logic        evStop,
  input  logic        evByte,
  input  logic [7:0]  byteData,
  output logic        ackOut,
  input  logic        popStrobe,
  output logic        irq,
  output logic [6:0]  notifyDev,
  output logic [15:0] notifyData
);
  hnStrobe_t strb;
  logic      fifoFull, fifoEmpty;

  hn_ctrl #(.HOST_ADDR(HOST_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .evStart(evStart), .evStop(evStop),
    .evByte(evByte), .byteData(byteData), .fifoFull(fifoFull),
    .strb(strb), .ackOut(ackOut)
  );

  hn_data #(.DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .byteData(byteData),
    .devIn(byteData[7:1]), .popReq(popStrobe), .full(fifoFull),
    .empty(fifoEmpty), .headDev(notifyDev), .headData(notifyData)
  );

  assign irq = !fifoEmpty;
endmodule

// File: tb/hostnotify_rx_test.sv
module hostnotify_rx_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evStart = 1'b0, evStop = 1'b0, evByte = 1'b0, popStrobe = 1'b0;
  logic [7:0]  byteData = '0;
  logic        ackOut, irq;
  logic [6:0]  notifyDev;
  logic [15:0] notifyData;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  hostnotify_rx uut (
    .clk(clk), .rstN(rstN), .evStart(evStart), .evStop(evStop),
    .evByte(evByte), .byteData(byteData), .ackOut(ackOut),
    .popStrobe(popStrobe), .irq(irq), .notifyDev(notifyDev),
    .notifyData(notifyData)
  );

  // {addressByte, devByte, low, high, bytes after address}
  localparam int NVEC = 7;
  localparam logic [35:0] VEC [NVEC] = '{
    {8'h10, 8'h5A, 8'h34, 8'h12, 4'd3},
    {8'h12, 8'h22, 8'h01, 8'h02, 4'd3},
    {8'h11, 8'h44, 8'h05, 8'h06, 4'd3},
    {8'h10, 8'h21, 8'hAB, 8'hCD, 4'd2},
    {8'h10, 8'hFF, 8'h01, 8'h80, 4'd3},
    {8'h10, 8'h80, 8'h11, 8'h99, 4'd4},
    {8'h10, 8'h00, 8'h00, 8'h00, 4'd0}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk); evStart = 1'b1;
    @(negedge clk); evStart = 1'b0;
  endtask

  task automatic pulseStop();
    @(negedge clk); evStop = 1'b1;
    @(negedge clk); evStop = 1'b0;
  endtask

  task automatic pulsePop();
    @(negedge clk); popStrobe = 1'b1;
    @(negedge clk); popStrobe = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, input logic expAck, input string tag);
    @(negedge clk); evByte = 1'b1; byteData = b;
    @(negedge clk); evByte = 1'b0;
    check(ackOut, expAck, tag);
  endtask

  task automatic sendFrame(input logic [6:0] dev, input logic [15:0] d, input logic expDevAck);
    pulseStart();
    sendByte(8'h10, 1'b1, "R2 address ack");
    sendByte({dev, 1'b1}, expDevAck, "R10/R5 device byte");
    sendByte(d[7:0], expDevAck, "R5 low byte");
    sendByte(d[15:8], expDevAck, "R5 high byte");
    pulseStop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(irq, 1'b0, "R1 irq reset");
    check(ackOut, 1'b0, "R1 ack reset");
    rstN = 1'b1;
    @(negedge clk);
    check(irq, 1'b0, "R1 queue empty");

    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] ab, db, lo, hi;
      int nb;
      logic match, queued;
      {ab, db, lo, hi} = VEC[i][35:4];
      nb = int'(VEC[i][3:0]);
      match  = (ab == 8'h10);
      queued = match && (nb == 3);
      pulseStart();
      sendByte(ab, match, "R2/R3 address byte");
      for (int k = 1; k <= nb; k++) begin
        logic [7:0] b;
        b = (k == 1) ? db : (k == 2) ? lo : hi;
        sendByte(b, match && (k <= 3), "R3/R5/R8 data-phase byte");
      end
      pulseStop();
      check(irq, queued, "R6/R8/R3 commit decision");
      if (queued) begin
        check(notifyDev, db[7:1], "R4 device address");
        check(notifyData, {hi, lo}, "R5 data word");
        pulsePop();
        check(irq, 1'b0, "R9 irq after drain");
      end
    end

    // R7: repeated start drops a partial frame
    pulseStart();
    sendByte(8'h10, 1'b1, "R7 first address");
    sendByte(8'h66, 1'b1, "R7 first dev");
    sendByte(8'h77, 1'b1, "R7 first low");
    pulseStart();
    sendByte(8'h10, 1'b1, "R7 restart address");
    sendByte(8'h3C, 1'b1, "R7 restart dev");
    sendByte(8'hEF, 1'b1, "R7 restart low");
    sendByte(8'hBE, 1'b1, "R7 restart high");
    pulseStop();
    check(notifyDev, 7'h1E, "R7 device after restart");
    check(notifyData, 16'hBEEF, "R7 data after restart");
    pulsePop();
    check(irq, 1'b0, "R7 single entry");

    // R9/R10: fill the queue, then overflow it
    for (int i = 0; i < 4; i++) sendFrame(7'(8'h40 + i), 16'(16'h1000 + i), 1'b1);
    check(irq, 1'b1, "R9 irq while full");
    sendFrame(7'h7A, 16'hDEAD, 1'b0);
    for (int i = 0; i < 4; i++) begin
      check(irq, 1'b1, "R9 irq nonempty");
      check(notifyDev, 32'(8'h40 + i), "R9/R10 order device");
      check(notifyData, 32'(16'h1000 + i), "R9/R10 order data");
      pulsePop();
    end
    check(irq, 1'b0, "R10 dropped frame absent");

    // R11: pop on empty does nothing
    pulsePop();
    check(irq, 1'b0, "R11 still empty");
    sendFrame(7'h15, 16'hA55A, 1'b1);
    check(notifyDev, 7'h15, "R11 head device intact");
    check(notifyData, 16'hA55A, "R11 head data intact");
    pulsePop();
    check(irq, 1'b0, "R11 drained");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule